// File: doc/BRIEF.md
# Receive FIFO Flow-Control Threshold Logic

This block sits at the receive side of a point-to-point packet link. Incoming 64-bit doublewords are written into a small FIFO. The block tracks how many doublewords are still free and drives a link-level flow-control line back to the remote transmitter. The line asks the sender to pause when free space drops under a programmable threshold. It also asks for a pause whenever the downstream DMA watermark logic raises its own request.

The output pin is shared with a management data function, so a direction input picks whether the block drives it. The threshold is 4 bits and is read on every cycle. A value of 0 turns off the threshold path. The suggested setting is 4 doublewords (32 bytes), and it should be raised when the remote sender adds a checksum tail after it sees the pause. Up to ten cycles of receive data, which is 10 bytes on a byte-wide link or 20 bytes on a 16-bit link, can already be on their way to the FIFO when the pause is raised. The threshold has to leave room for that data. The FIFO in this block is a model store that shows whether any data would have been lost.

The flow-control decision is held in a three-state machine that is clocked once per cycle. FC_OFF drives the line low, FC_ON drives it high, and FC_HIZ releases the line. From any state the machine moves as follows: to FC_HIZ when the direction input selects input; to FC_ON when the direction selects output and a request is present; to FC_OFF when the direction selects output and there is no request. Both pin outputs therefore follow their inputs with exactly one cycle of delay.

Top module: `rxfc_top`

## Requirements
- R1: After reset, fc_pin_o is 0, fc_oe_o is 1, free_dw_o equals DEPTH (16), overflow_o is 0 and rd_valid_o is 0.
- R2: With fc_dir_out_i=1 and a nonzero fc_thresh_i, fc_pin_o is 1 in the cycle after free_dw_o < fc_thresh_i holds, and 0 in the cycle after it does not hold (if no watermark request is present).
- R3: A write attempted while the FIFO holds DEPTH entries and no read is accepted is dropped. overflow_o is 1 in that same cycle, the stored contents are unchanged, and occupancy never exceeds DEPTH. A write and a read together on a full FIFO are both accepted.
- R4: With fc_dir_out_i=1, dma_wm_req_i=1 makes fc_pin_o 1 in the next cycle, whatever the threshold and fill level.
- R5: fc_thresh_i=0 never raises fc_pin_o by itself, even when the FIFO is full.
- R6: With fc_dir_out_i=0, both fc_oe_o and fc_pin_o are 0 in the next cycle, whatever the requests.
- R7: The pin outputs always show the request and direction from the previous cycle, never those from the current cycle.
- R8: Reads return doublewords in write order. rd_valid_o is 0 when the FIFO is empty, and a read on an empty FIFO changes nothing.
- R9: free_dw_o equals DEPTH minus the number of doublewords stored, and is updated on the clock edge of each accepted write or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Write one received doubleword |
| wr_dword_i | input | 64 | Received doubleword |
| rd_req_i | input | 1 | Pop the oldest doubleword |
| rd_dword_o | output | 64 | Oldest stored doubleword (show-ahead) |
| rd_valid_o | output | 1 | FIFO holds at least one entry |
| free_dw_o | output | 5 | Free doubleword count |
| overflow_o | output | 1 | Write dropped this cycle because FIFO is full |
| fc_thresh_i | input | 4 | Free-space threshold in doublewords, 0 disables |
| dma_wm_req_i | input | 1 | DMA watermark pause request |
| fc_dir_out_i | input | 1 | 1 = block drives the shared pin |
| fc_pin_o | output | 1 | Flow-control value toward the remote sender |
| fc_oe_o | output | 1 | Output enable for the shared pin |

## Verification
Several properties are checked on every cycle. The pin equals the request and direction from one cycle earlier. A released pin never carries a 1. Occupancy stays within the depth. A write on a full FIFO, or a read on an empty one, leaves the pointers unchanged. The bench sweeps every threshold value against every fill level from empty to full and back, and computes the expected pin from the fill count. Only these scenarios show that the threshold comparison is exact at each boundary, that data comes out in order, and that dropped writes are flagged at the port.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    // States of the flow-control line driver
    typedef enum logic [1:0] {
        FC_OFF = 2'd0,   // driving low, sender may transmit
        FC_ON  = 2'd1,   // driving high, sender must pause
        FC_HIZ = 2'd2    // pin released to the management function
    } fc_state_e;

endpackage

// File: rtl/rxfc_dw_fifo.sv
module rxfc_dw_fifo #(
    parameter int DW    = 64,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_req,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    output logic [CNTW-1:0] free_dw,
    output logic            ovf
);

    localparam logic [CNTW-1:0] DEPTH_C = CNTW'(DEPTH);
    localparam logic [AW-1:0]   LAST_C  = AW'(DEPTH - 1);

    logic [DW-1:0]   mem_q [DEPTH];
    logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CNTW-1:0] count_q;
    logic            do_wr, do_rd;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == LAST_C) ? '0 : p + AW'(1);
    endfunction

    assign do_rd    = rd_req && (count_q != '0);
    assign do_wr    = wr_valid && ((count_q != DEPTH_C) || do_rd);
    assign ovf      = wr_valid && !do_wr;
    assign rd_valid = (count_q != '0);
    assign rd_data  = mem_q[rd_ptr_q];
    assign free_dw  = DEPTH_C - count_q;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_q[wr_ptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_wr) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (do_rd) rd_ptr_q <= ptr_next(rd_ptr_q);
            unique case ({do_wr, do_rd})
                2'b10:   count_q <= count_q + CNTW'(1);
                2'b01:   count_q <= count_q - CNTW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // R3: occupancy bounded by depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= DEPTH_C);

    // R3: a write into a full FIFO without a read is dropped
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == DEPTH_C && wr_valid && !rd_req)
        |=> (count_q == DEPTH_C && $stable(wr_ptr_q)));

    // R8: a read of an empty FIFO changes nothing
    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && rd_req && !wr_valid)
        |=> (count_q == '0 && $stable(rd_ptr_q)));

endmodule

// File: rtl/rxfc_req_eval.sv
module rxfc_req_eval #(
    parameter int CNTW = 5,
    parameter int THW  = 4,
    localparam int CW  = (CNTW > THW) ? CNTW : THW
) (
    input  logic [CNTW-1:0] free_dw_i,
    input  logic [THW-1:0]  thresh_i,
    input  logic            dma_wm_i,
    output logic            req_o
);

    logic [CW-1:0] free_ext, thr_ext;
    logic          thr_hit;

    assign free_ext = CW'(free_dw_i);
    assign thr_ext  = CW'(thresh_i);

    // A zero threshold switches the free-space path off
    assign thr_hit = (thresh_i != '0) && (free_ext < thr_ext);
    assign req_o   = thr_hit || dma_wm_i;

endmodule

// File: rtl/rxfc_fc_fsm.sv
module rxfc_fc_fsm
    import rxfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic dir_out_i,
    output logic fc_pin_o,
    output logic fc_oe_o
);

    fc_state_e state_q, state_d;
    logic      started_q;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_OFF: begin
                if (!dir_out_i)  state_d = FC_HIZ;
                else if (req_i)  state_d = FC_ON;
            end
            FC_ON: begin
                if (!dir_out_i)  state_d = FC_HIZ;
                else if (!req_i) state_d = FC_OFF;
            end
            FC_HIZ: begin
                if (dir_out_i)   state_d = req_i ? FC_ON : FC_OFF;
            end
            default:             state_d = FC_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FC_OFF;
            started_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            started_q <= 1'b1;
        end
    end

    // Outputs from state
    always_comb begin
        unique case (state_q)
            FC_OFF:  begin fc_pin_o = 1'b0; fc_oe_o = 1'b1; end
            FC_ON:   begin fc_pin_o = 1'b1; fc_oe_o = 1'b1; end
            FC_HIZ:  begin fc_pin_o = 1'b0; fc_oe_o = 1'b0; end
            default: begin fc_pin_o = 1'b0; fc_oe_o = 1'b0; end
        endcase
    end

    // R7: pin follows previous-cycle request and direction
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (fc_pin_o == ($past(req_i) && $past(dir_out_i))));

    // R6: released pin carries no value
    p_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !$past(dir_out_i)) |-> (!fc_oe_o && !fc_pin_o));

endmodule

// File: rtl/rxfc_top.sv
module rxfc_top #(
    parameter int DW    = 64,
    parameter int DEPTH = 16,
    parameter int THW   = 4,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid_i,
    input  logic [DW-1:0]   wr_dword_i,
    input  logic            rd_req_i,
    output logic [DW-1:0]   rd_dword_o,
    output logic            rd_valid_o,
    output logic [CNTW-1:0] free_dw_o,
    output logic            overflow_o,
    input  logic [THW-1:0]  fc_thresh_i,
    input  logic            dma_wm_req_i,
    input  logic            fc_dir_out_i,
    output logic            fc_pin_o,
    output logic            fc_oe_o
);

    localparam int CW = (CNTW > THW) ? CNTW : THW;

    logic fc_req;

    rxfc_dw_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid_i),
        .wr_data  (wr_dword_i),
        .rd_req   (rd_req_i),
        .rd_data  (rd_dword_o),
        .rd_valid (rd_valid_o),
        .free_dw  (free_dw_o),
        .ovf      (overflow_o)
    );

    rxfc_req_eval #(.CNTW(CNTW), .THW(THW)) u_eval (
        .free_dw_i (free_dw_o),
        .thresh_i  (fc_thresh_i),
        .dma_wm_i  (dma_wm_req_i),
        .req_o     (fc_req)
    );

    rxfc_fc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (fc_req),
        .dir_out_i (fc_dir_out_i),
        .fc_pin_o  (fc_pin_o),
        .fc_oe_o   (fc_oe_o)
    );

    // R4: watermark request forces a pause next cycle
    p_wm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dma_wm_req_i && fc_dir_out_i)) |-> fc_pin_o);

    // R2: free space under threshold forces a pause next cycle
    p_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fc_dir_out_i && (fc_thresh_i != '0)
            && (CW'(free_dw_o) < CW'(fc_thresh_i)))) |-> fc_pin_o);

    // R5: zero threshold alone never pauses
    p_thr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past((fc_thresh_i == '0) && !dma_wm_req_i)) |-> !fc_pin_o);

endmodule

// File: tb/rxfc_top_tb.sv
module rxfc_top_tb;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid_i, rd_req_i;
    logic [63:0] wr_dword_i, rd_dword_o;
    logic        rd_valid_o, overflow_o;
    logic [4:0]  free_dw_o;
    logic [3:0]  fc_thresh_i;
    logic        dma_wm_req_i, fc_dir_out_i;
    logic        fc_pin_o, fc_oe_o;

    int checks = 0;
    int errors = 0;
    int fill   = 0;
    int seq    = 0;
    bit done   = 1'b0;
    logic [63:0] model_q[$];

    always #2 clk = ~clk;

    rxfc_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid_i(wr_valid_i), .wr_dword_i(wr_dword_i), .rd_req_i(rd_req_i),
        .rd_dword_o(rd_dword_o), .rd_valid_o(rd_valid_o), .free_dw_o(free_dw_o),
        .overflow_o(overflow_o), .fc_thresh_i(fc_thresh_i),
        .dma_wm_req_i(dma_wm_req_i), .fc_dir_out_i(fc_dir_out_i),
        .fc_pin_o(fc_pin_o), .fc_oe_o(fc_oe_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (thr=%0d fill=%0d wm=%0d dir=%0d)",
                     tag, act, exp, fc_thresh_i, fill, dma_wm_req_i, fc_dir_out_i);
        end
    endtask

    function automatic logic exp_req();
        return fc_dir_out_i && (((fc_thresh_i != 0) && ((DEPTH - fill) < int'(fc_thresh_i)))
                                || dma_wm_req_i);
    endfunction

    function automatic string pin_tag();
        if (!fc_dir_out_i)     return "R6";
        if (dma_wm_req_i)      return "R4";
        if (fc_thresh_i == 0)  return "R5";
        return "R2";
    endfunction

    // One FIFO operation, started at a negedge; ends at a negedge two cycles later
    task automatic op(input bit wr, input bit rd);
        logic        prev_req;
        bit          acc_rd, acc_wr;
        logic [63:0] d;
        prev_req = exp_req();
        acc_rd   = rd && (fill > 0);
        acc_wr   = wr && ((fill < DEPTH) || acc_rd);
        d        = {32'(seq) * 32'h9E37_79B9, 32'(seq)};
        seq++;
        wr_valid_i = wr;
        wr_dword_i = d;
        rd_req_i   = rd;
        #1;
        chk("R3 overflow flag", 64'(overflow_o), 64'(wr && !acc_wr));
        chk("R8 rd_valid", 64'(rd_valid_o), 64'(fill > 0));
        if (acc_rd) chk("R8 order", rd_dword_o, model_q[0]);
        @(negedge clk);
        wr_valid_i = 1'b0;
        rd_req_i   = 1'b0;
        if (acc_rd) void'(model_q.pop_front());
        if (acc_wr) model_q.push_back(d);
        fill = fill + int'(acc_wr) - int'(acc_rd);
        chk("R9 free count", 64'(free_dw_o), 64'(DEPTH - fill));
        chk("R7 one-cycle latency", 64'(fc_pin_o), 64'(prev_req));
        @(negedge clk);
        chk(pin_tag(), 64'(fc_pin_o), 64'(exp_req()));
        chk("R6 output enable", 64'(fc_oe_o), 64'(fc_dir_out_i));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_valid_i = 1'b0; rd_req_i = 1'b0; wr_dword_i = '0;
        fc_thresh_i = 4'd0; dma_wm_req_i = 1'b0; fc_dir_out_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pin", 64'(fc_pin_o), 64'd0);
        chk("R1 oe", 64'(fc_oe_o), 64'd1);
        chk("R1 free", 64'(free_dw_o), 64'(DEPTH));
        chk("R1 overflow", 64'(overflow_o), 64'd0);
        chk("R1 rd_valid", 64'(rd_valid_o), 64'd0);

        // Every threshold against every fill level, up and down
        for (int t = 0; t < 16; t++) begin
            fc_thresh_i = 4'(t);
            @(negedge clk);
            for (int k = 0; k <= DEPTH; k++) op(1'b1, 1'b0);
            for (int k = 0; k <= DEPTH; k++) op(1'b0, 1'b1);
        end

        // R3: simultaneous write and read on a full FIFO
        fc_thresh_i = 4'd4;
        for (int k = 0; k < DEPTH; k++) op(1'b1, 1'b0);
        op(1'b1, 1'b1);
        op(1'b1, 1'b0);
        chk("R3 still full", 64'(free_dw_o), 64'd0);

        // R4: watermark with threshold off at several fills
        fc_thresh_i = 4'd0;
        dma_wm_req_i = 1'b1;
        for (int k = 0; k <= DEPTH; k++) op(1'b0, 1'b1);
        op(1'b1, 1'b0);

        // R6: direction released with both requests active
        fc_thresh_i = 4'd15;
        fc_dir_out_i = 1'b0;
        op(1'b1, 1'b0);
        op(1'b0, 1'b1);
        dma_wm_req_i = 1'b0;
        op(1'b0, 1'b1);
        fc_dir_out_i = 1'b1;
        op(1'b1, 1'b0);
        for (int k = 0; k <= DEPTH; k++) op(1'b0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule